// File: doc/BRIEF.md
# Sleep and Wakeup Sequencer with Real-Time Counter

This block keeps a 48-bit real-time counter that advances on slow-clock ticks and can never be written. The counter also drives a compare that acts as a timer wakeup source. The same block runs the path into and out of a low-power state. Software first sets up a wakeup source mask, a reject mask, a light/deep selector, a counter target and three oscillator settle counts. It then pulses `start`. The block checks for reject activity once. If nothing blocks it, the block sleeps until an enabled event arrives, then brings the clock sources back in a fixed order. After a light sleep it returns to idle. After a deep sleep it also asks for a CPU reset.

Event inputs arrive asynchronously and each passes through two flip-flops before use. The block runs on the fast clock. The slow clock appears as a one-cycle enable, `slow_tick`. Regulators and analog switches are outside the block. The block's only outputs toward them are three plain enables: the internal oscillator, the crystal and the PLL.

The states are IDLE, CHECK, SLEEP, WAIT_OSC, WAIT_XTAL, WAIT_PLL and RESET_REQ. The transitions are:
- IDLE to CHECK on `start`.
- CHECK to IDLE on a reject, or CHECK to SLEEP otherwise.
- SLEEP to WAIT_OSC on an enabled event.
- WAIT_OSC to WAIT_XTAL to WAIT_PLL, each when its count is used up.
- WAIT_PLL to IDLE after a light sleep, or WAIT_PLL to RESET_REQ after a deep sleep.
- RESET_REQ to IDLE unconditionally.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset the outputs are as follows. `rtc_count` is 0. `asleep`, `busy`, `rejected`, `cpu_reset_req` and `wake_cause` are 0. `osc_en`, `xtal_en` and `pll_en` are 1.
- R2: `rtc_count` rises by exactly one on each clock edge where `slow_tick` is high. It holds otherwise, including while asleep. No input can load it.
- R3: The reject mask uses bit 0 for GPIO activity (`ev_in[2]`) and bit 1 for SDIO activity (`ev_in[4]`). The block samples it against the synchronized activity once, on the cycle after `start`. On a match, `rejected` goes to 1, `asleep` never rises, and `busy` returns to 0 one cycle later.
- R4: Without a reject, `asleep` goes to 1 two cycles after the `start` edge. While asleep, `osc_en`, `xtal_en` and `pll_en` are all 0.
- R5: The wake mask bits are: 0 EXT0, 1 EXT1, 2 GPIO, 3 timer, 4 SDIO, 5 MAC, 6 UART0, 7 UART1, 8 touch, 9 ULP, 10 BT. Bit n of `ev_in` is source n, and `ev_in[3]` is not used. Only enabled events end sleep. `wake_cause` takes all enabled sources active in the first such cycle.
- R6: In deep sleep (`deep_sel`=1) the sources GPIO, SDIO, MAC, UART0, UART1 and BT (bits 2, 4, 5, 6, 7, 10) are ignored.
- R7: The timer source (bit 3) is active while `rtc_count` equals `wake_target`.
- R8: On wakeup, WAIT_OSC lasts `wait_osc`+1 cycles with only `osc_en` high. WAIT_XTAL then lasts `wait_xtal`+1 cycles with `xtal_en` added. WAIT_PLL then lasts `wait_pll`+1 cycles with `pll_en` added.
- R9: After a light sleep the block goes back to idle with no reset request. After a deep sleep, `cpu_reset_req` is high for exactly one cycle following WAIT_PLL.
- R10: An accepted `start` clears `wake_cause` and `rejected`. A `start` outside IDLE has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| start | input | 1 | Sleep request strobe |
| deep_sel | input | 1 | 1 = deep sleep, 0 = light sleep |
| wake_mask | input | 11 | Wakeup source enables |
| reject_mask | input | 2 | Reject enables: bit0 GPIO, bit1 SDIO |
| wake_target | input | 48 | Counter value for timer wakeup |
| ev_in | input | 11 | Asynchronous event inputs, bit n = source n |
| wait_osc | input | 8 | Internal oscillator settle count |
| wait_xtal | input | 8 | Crystal settle count |
| wait_pll | input | 8 | PLL settle count |
| rtc_count | output | 48 | Real-time counter |
| asleep | output | 1 | High in SLEEP |
| busy | output | 1 | High outside IDLE |
| wake_cause | output | 11 | Latched wakeup sources |
| rejected | output | 1 | Last request was rejected |
| cpu_reset_req | output | 1 | One-cycle CPU reset request after deep wakeup |
| osc_en | output | 1 | Internal oscillator enable |
| xtal_en | output | 1 | Crystal enable |
| pll_en | output | 1 | PLL enable |

## Verification
Several properties are checked on every cycle:
- The counter steps only on ticks.
- The enables keep their order (PLL implies crystal implies oscillator).
- A rejected request never sleeps.
- The cause register stays clear while asleep and is nonzero on leaving sleep.
- A deep wakeup never records a light-only source.
- The reset request lasts a single cycle.

Other behaviour can only be shown by the bench's scenarios. This includes the exact cause value for a given mix of events and masks, and the total settle duration for given counts. It also includes the timer wakeup landing on the target, disabled events leaving the block asleep, and a stray `start` during sleep being ignored.

// File: rtl/swc_pkg.sv
package swc_pkg;
    localparam int NSRC      = 11;
    localparam int SRC_GPIO  = 2;
    localparam int SRC_TIMER = 3;
    localparam int SRC_SDIO  = 4;
    // sources 2,4,5,6,7,10 are only meaningful in light sleep
    localparam logic [NSRC-1:0] LIGHT_ONLY = 11'b100_1111_0100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SLEEP,
        ST_WAIT_OSC,
        ST_WAIT_XTAL,
        ST_WAIT_PLL,
        ST_RESET_REQ
    } swc_state_e;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/swc_rtc.sv
module swc_rtc #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (tick)  count <= count + CNT_W'(1);
    end

    assign hit = (count == target);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count == ($past(count) + CNT_W'(1)));
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
endmodule

// File: rtl/swc_seq.sv
module swc_seq
    import swc_pkg::*;
#(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              deep_sel,
    input  logic [NSRC-1:0]   wake_mask,
    input  logic [1:0]        reject_mask,
    input  logic [NSRC-1:0]   ev_sync,
    input  logic              timer_hit,
    input  logic [WAIT_W-1:0] wait_osc,
    input  logic [WAIT_W-1:0] wait_xtal,
    input  logic [WAIT_W-1:0] wait_pll,
    output logic              asleep,
    output logic              busy,
    output logic [NSRC-1:0]   wake_cause,
    output logic              rejected,
    output logic              cpu_reset_req,
    output logic              osc_en,
    output logic              xtal_en,
    output logic              pll_en
);
    swc_state_e        state_q, state_d;
    logic              deep_q;
    logic [NSRC-1:0]   mask_q;
    logic [1:0]        rmask_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic [NSRC-1:0]   ev_all, eff_mask, hits;
    logic              rej_hit, wcnt_zero;

    always_comb begin
        ev_all            = ev_sync;
        ev_all[SRC_TIMER] = timer_hit;
        eff_mask          = deep_q ? (mask_q & ~LIGHT_ONLY) : mask_q;
        hits              = ev_all & eff_mask;
        rej_hit           = |(rmask_q & {ev_sync[SRC_SDIO], ev_sync[SRC_GPIO]});
        wcnt_zero         = (wcnt_q == '0);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start)     state_d = ST_CHECK;
            ST_CHECK:     state_d = rej_hit ? ST_IDLE : ST_SLEEP;
            ST_SLEEP:     if (|hits)     state_d = ST_WAIT_OSC;
            ST_WAIT_OSC:  if (wcnt_zero) state_d = ST_WAIT_XTAL;
            ST_WAIT_XTAL: if (wcnt_zero) state_d = ST_WAIT_PLL;
            ST_WAIT_PLL:  if (wcnt_zero) state_d = deep_q ? ST_RESET_REQ : ST_IDLE;
            ST_RESET_REQ: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register, captured configuration and settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            deep_q  <= 1'b0;
            mask_q  <= '0;
            rmask_q <= '0;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                deep_q  <= deep_sel;
                mask_q  <= wake_mask;
                rmask_q <= reject_mask;
            end
            if (state_d != state_q) begin
                unique case (state_d)
                    ST_WAIT_OSC:  wcnt_q <= wait_osc;
                    ST_WAIT_XTAL: wcnt_q <= wait_xtal;
                    ST_WAIT_PLL:  wcnt_q <= wait_pll;
                    default:      wcnt_q <= wcnt_q;
                endcase
            end else if (!wcnt_zero) begin
                wcnt_q <= wcnt_q - WAIT_W'(1);
            end
        end
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_cause <= '0;
            rejected   <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            wake_cause <= '0;
            rejected   <= 1'b0;
        end else if (state_q == ST_CHECK && rej_hit) begin
            rejected   <= 1'b1;
        end else if (state_q == ST_SLEEP && |hits) begin
            wake_cause <= hits;
        end
    end

    // state-decoded outputs
    always_comb begin
        asleep        = 1'b0;
        busy          = 1'b1;
        cpu_reset_req = 1'b0;
        osc_en        = 1'b1;
        xtal_en       = 1'b1;
        pll_en        = 1'b1;
        unique case (state_q)
            ST_IDLE:      busy = 1'b0;
            ST_CHECK:     ;
            ST_SLEEP:     begin asleep = 1'b1; osc_en = 1'b0; xtal_en = 1'b0; pll_en = 1'b0; end
            ST_WAIT_OSC:  begin xtal_en = 1'b0; pll_en = 1'b0; end
            ST_WAIT_XTAL: pll_en = 1'b0;
            ST_WAIT_PLL:  ;
            ST_RESET_REQ: cpu_reset_req = 1'b1;
            default:      ;
        endcase
    end

    assert_reject_no_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> !asleep);
    assert_cause_clear_asleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |-> (wake_cause == '0));
    assert_cause_on_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_OSC && $past(state_q) == ST_SLEEP) |-> (wake_cause != '0));
    assert_deep_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_OSC && $past(state_q) == ST_SLEEP && deep_q)
        |-> ((wake_cause & LIGHT_ONLY) == '0));
    assert_enable_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en |-> xtal_en) and (xtal_en |-> osc_en));
    assert_reset_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_req |=> !cpu_reset_req);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import swc_pkg::*;
#(
    parameter int CNT_W  = 48,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              start,
    input  logic              deep_sel,
    input  logic [NSRC-1:0]   wake_mask,
    input  logic [1:0]        reject_mask,
    input  logic [CNT_W-1:0]  wake_target,
    input  logic [NSRC-1:0]   ev_in,
    input  logic [WAIT_W-1:0] wait_osc,
    input  logic [WAIT_W-1:0] wait_xtal,
    input  logic [WAIT_W-1:0] wait_pll,
    output logic [CNT_W-1:0]  rtc_count,
    output logic              asleep,
    output logic              busy,
    output logic [NSRC-1:0]   wake_cause,
    output logic              rejected,
    output logic              cpu_reset_req,
    output logic              osc_en,
    output logic              xtal_en,
    output logic              pll_en
);
    logic [NSRC-1:0] ev_sync;
    logic            timer_hit;

    swc_sync #(.W(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(ev_in), .q(ev_sync)
    );

    swc_rtc #(.CNT_W(CNT_W)) u_rtc (
        .clk(clk), .rst_n(rst_n), .tick(slow_tick), .target(wake_target),
        .count(rtc_count), .hit(timer_hit)
    );

    swc_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .deep_sel(deep_sel),
        .wake_mask(wake_mask), .reject_mask(reject_mask), .ev_sync(ev_sync),
        .timer_hit(timer_hit), .wait_osc(wait_osc), .wait_xtal(wait_xtal),
        .wait_pll(wait_pll), .asleep(asleep), .busy(busy),
        .wake_cause(wake_cause), .rejected(rejected),
        .cpu_reset_req(cpu_reset_req), .osc_en(osc_en), .xtal_en(xtal_en),
        .pll_en(pll_en)
    );
endmodule

// File: tb/sim_sleep_wake_ctrl.sv
module sim_sleep_wake_ctrl;
    localparam logic [10:0] LIGHT = 11'b100_1111_0100;

    logic        clk = 0, rst_n = 0, slow_tick = 0, start = 0, deep_sel = 0;
    logic [10:0] wake_mask = 0, ev_in = 0;
    logic [1:0]  reject_mask = 0;
    logic [47:0] wake_target = '1;
    logic [7:0]  wait_osc = 0, wait_xtal = 0, wait_pll = 0;
    logic [47:0] rtc_count;
    logic        asleep, busy, rejected, cpu_reset_req, osc_en, xtal_en, pll_en;
    logic [10:0] wake_cause;

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit tick_on = 0, done = 0;
    logic [47:0] exp_cnt = 0;
    logic [1:0]  div = 0;

    sleep_wake_ctrl u0 (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) exp_cnt <= 0;
        else if (slow_tick) exp_cnt <= exp_cnt + 1;
    end

    always @(negedge clk) begin
        div       <= div + 1;
        slow_tick <= tick_on && (div == 2'd3);
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] eff_of(input bit deep, input logic [10:0] m);
        return deep ? (m & ~LIGHT) : m;
    endfunction

    function automatic bit rej_of(input logic [1:0] rm, input logic [10:0] act);
        return |(rm & {act[4], act[2]});
    endfunction

    task automatic trial(input bit deep, input logic [10:0] mask, input logic [1:0] rmask,
                         input logic [10:0] pre, input logic [10:0] wake, input bit use_timer,
                         input logic [7:0] w0, input logic [7:0] w1, input logic [7:0] w2);
        logic [10:0] exp_cause;
        logic [47:0] tgt;
        int n, dur;
        exp_cause = use_timer ? 11'h008 : (wake & eff_of(deep, mask) & ~11'h008);
        @(negedge clk);
        deep_sel = deep; wake_mask = mask; reject_mask = rmask; ev_in = pre;
        wait_osc = w0; wait_xtal = w1; wait_pll = w2;
        tgt = use_timer ? exp_cnt + 48'd25 : '1;
        wake_target = tgt;
        repeat (3) @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        chk(wake_cause == 0 && rejected == 0, "R10 clear on start", {wake_cause, rejected}, 0);
        @(negedge clk);
        if (rej_of(rmask, pre)) begin
            chk(rejected && !asleep, "R3 reject", {rejected, asleep}, 2'b10);
            @(negedge clk);
            chk(!busy && !asleep, "R3 back to idle", {busy, asleep}, 0);
            ev_in = 0;
            return;
        end
        chk(asleep && !rejected, "R4 sleep entry", {asleep, rejected}, 2'b10);
        chk(!osc_en && !xtal_en && !pll_en, "R4 enables off", {osc_en, xtal_en, pll_en}, 0);
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (5) @(negedge clk);
        chk(asleep, "R5 R6 disabled events ignored", asleep, 1);
        chk(wake_cause == 0, "R10 start ignored while asleep", wake_cause, 0);
        chk(rtc_count == exp_cnt, "R2 counter runs in sleep", rtc_count, exp_cnt);
        if (!use_timer) ev_in = wake;
        n = 0;
        while (asleep && n < 400) begin @(negedge clk); n++; end
        chk(!asleep, "R5 wakeup occurred", asleep, 0);
        if (use_timer)
            chk(rtc_count == tgt || rtc_count == tgt + 1, "R7 timer match", rtc_count, tgt);
        chk(osc_en && !xtal_en && !pll_en, "R8 oscillator first", {osc_en, xtal_en, pll_en}, 3'b100);
        dur = 0;
        while (busy && !cpu_reset_req && dur < 2000) begin
            if (dur == int'(w0) + 1)
                chk(osc_en && xtal_en && !pll_en, "R8 crystal second", {osc_en, xtal_en, pll_en}, 3'b110);
            dur++;
            @(negedge clk);
        end
        chk(dur == int'(w0) + int'(w1) + int'(w2) + 3, "R8 settle duration", dur, w0 + w1 + w2 + 3);
        if (deep) begin
            chk(cpu_reset_req, "R9 deep reset request", cpu_reset_req, 1);
            @(negedge clk);
            chk(!cpu_reset_req && !busy, "R9 reset single cycle", {cpu_reset_req, busy}, 0);
        end else begin
            chk(!cpu_reset_req && !busy, "R9 light returns idle", {cpu_reset_req, busy}, 0);
        end
        chk(wake_cause == exp_cause, "R5 R6 wake cause", wake_cause, exp_cause);
        ev_in = 0;
    endtask

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rtc_count == 0 && !asleep && !busy && !rejected && !cpu_reset_req && wake_cause == 0,
            "R1 reset outputs", {rtc_count, asleep, busy, rejected, cpu_reset_req}, 0);
        chk(osc_en && xtal_en && pll_en, "R1 enables on", {osc_en, xtal_en, pll_en}, 3'b111);
        tick_on = 1;
        repeat (40) @(negedge clk);
        chk(rtc_count == exp_cnt && exp_cnt != 0, "R2 counter steps per tick", rtc_count, exp_cnt);

        // directed corners
        trial(0, 11'h001, 2'b00, 11'h022, 11'h001, 0, 8'd2, 8'd3, 8'd4);   // light, EXT0
        trial(1, 11'h005, 2'b00, 11'h004, 11'h005, 0, 8'd1, 8'd1, 8'd1);   // R6 deep ignores GPIO
        trial(0, 11'h001, 2'b01, 11'h004, 11'h001, 0, 8'd0, 8'd0, 8'd0);   // R3 GPIO reject
        trial(0, 11'h001, 2'b10, 11'h010, 11'h001, 0, 8'd0, 8'd0, 8'd0);   // R3 SDIO reject
        trial(0, 11'h001, 2'b10, 11'h004, 11'h001, 0, 8'd0, 8'd0, 8'd0);   // R3 non-matching
        trial(1, 11'h008, 2'b00, 11'h000, 11'h000, 1, 8'd5, 8'd0, 8'd2);   // R7 timer, deep
        trial(0, 11'h408, 2'b00, 11'h000, 11'h000, 1, 8'd0, 8'd7, 8'd0);   // R7 timer, light
        trial(0, 11'h7ff, 2'b00, 11'h000, 11'h6f7, 0, 8'd3, 8'd3, 8'd3);   // R5 several at once

        // random trials
        for (int i = 0; i < 24; i++) begin
            bit          deep;
            int          s;
            logic [10:0] m, pre, wk, eff;
            deep = 1'($urandom % 2);
            s = int'($urandom % 11);
            if (s == 3) s = 0;
            if (deep && LIGHT[s]) s = 1;
            m   = 11'($urandom) | (11'd1 << s);
            eff = eff_of(deep, m);
            pre = 11'($urandom) & ~eff;
            wk  = pre | (11'd1 << s) | (11'($urandom) & eff);
            trial(deep, m, 2'b00, pre, wk, 0,
                  8'($urandom % 8), 8'($urandom % 8), 8'($urandom % 8));
        end

        repeat (20) @(negedge clk);
        chk(rtc_count == exp_cnt, "R2 counter final", rtc_count, exp_cnt);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule